// File: doc/BRIEF.md
# Debounced Single-Pulse Button Conditioner

This block takes raw, bouncing push-button levels and turns each press into a strobe that is high for exactly one clock cycle. A tester can then advance a sequential design by one step per press, for example by using the strobe as the count qualifier of an 8-bit counter.

All channels share one free-running sampling timer. Each channel captures its raw input only when the timer reaches its last value. That coarse sampling removes contact bounce. The captured level passes through one alignment register and then into a three-state edge machine, which emits the strobe.

The machine has three states:

- `ST_IDLE` waits for a high aligned sample. It moves IDLE→FIRE when the aligned level is high.
- `ST_FIRE` is the single strobe cycle. It moves FIRE→HOLD while the level stays high, and FIRE→IDLE when the level is already low.
- `ST_HOLD` waits for the release. It moves HOLD→IDLE when the aligned level goes low.

Top module: `press_strobe`

## Requirements
- R1: Every strobe on `step_en` lasts exactly one clock cycle.
- R2: The sampling timer is a free-running `CNT_W`-bit counter (parameter, default 16) that reset clears to zero. A channel captures its raw input only on the cycle the timer holds all ones. Raw activity that starts and ends between two such cycles has no effect on `step_en`.
- R3: When the first sample edge that sees a raw input high is clock edge E, the matching strobe is high in the cycle after edge E+2, and low in the cycles after E+1 and E+3.
- R4: A button held high produces one strobe only. A further strobe needs at least one sample that sees the button low.
- R5: There are `N_BTN` channels (default 4), one per bit of `btn_raw` and `step_en`. They share one timer. A press on one channel produces no strobe on any other channel.
- R6: Synchronous reset clears the timer and all channel state. `step_en` is zero while reset is high and in the first cycle after reset falls, even if a strobe was about to fire.
- R7: A press whose bounce settles within one sampling period yields exactly one strobe.
- R8: Releasing a button, with or without bounce, produces no strobe.
- R9: The strobes can qualify a downstream counter so that it advances by exactly one per press. N clean presses give N strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | N_BTN | Raw button levels, bit i is channel i |
| step_en | output | N_BTN | One-cycle strobe per press, bit i is channel i |

## Verification
The bench drives several input patterns, each aimed at one failure mode:

- A clean hold checks the exact strobe cycle against the sampling phase and shows that holding does not repeat.
- A burst of toggles that settles before the next sample shows that bounce collapses to a single strobe. Bounce on release shows that release stays silent.
- A short pulse placed wholly between two samples shows that samples are taken only at the timer's end value.
- Simultaneous and single-channel presses separate shared timing from per-channel state.
- A reset that lands one cycle before a due strobe shows that reset clears the pipeline.

// File: rtl/press_strobe_pkg.sv
package press_strobe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } edge_state_t;
endpackage

// File: rtl/strobe_timer.sv
module strobe_timer #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/press_chan.sv
module press_chan
    import press_strobe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic fire
);
    logic        smp_q;
    logic        aln_q;
    edge_state_t state_q;
    edge_state_t state_d;

    // sample register and alignment stage
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= 1'b0;
            aln_q <= 1'b0;
        end else begin
            if (tick) begin
                smp_q <= raw;
            end
            aln_q <= smp_q;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (aln_q) state_d = ST_FIRE;
            ST_FIRE: state_d = aln_q ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!aln_q) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_IDLE: fire = 1'b0;
            ST_FIRE: fire = 1'b1;
            ST_HOLD: fire = 1'b0;
            default: fire = 1'b0;
        endcase
    end

    // R2
    smp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(smp_q));

    // R1
    fire_width_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R4
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && aln_q) |=> !fire);

    // R3
    fire_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(aln_q));
endmodule

// File: rtl/press_strobe.sv
module press_strobe #(
    parameter int CNT_W = 16,
    parameter int N_BTN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_BTN-1:0] btn_raw,
    output logic [N_BTN-1:0] step_en
);
    logic tick;

    strobe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    generate
        for (genvar i = 0; i < N_BTN; i++) begin : g_chan
            press_chan u_chan (
                .clk  (clk),
                .rst  (rst),
                .tick (tick),
                .raw  (btn_raw[i]),
                .fire (step_en[i])
            );
        end
    endgenerate

    // R6
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (step_en == '0));
endmodule

// File: tb/press_strobe_bench.sv
module press_strobe_bench;
    localparam int CW  = 4;
    localparam int NB  = 4;
    localparam int PER = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] btn_raw = '0;
    logic [NB-1:0] step_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int pulses [NB];
    int wide_err = 0;
    logic [NB-1:0] prev_en = '0;

    press_strobe #(.CNT_W(CW), .N_BTN(NB)) u_press_strobe (
        .clk(clk), .rst(rst), .btn_raw(btn_raw), .step_en(step_en)
    );

    always #10 clk = ~clk;

    // edges since reset release
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // monitor: count strobes and catch wide ones
    always @(negedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (step_en[b]) begin
                pulses[b] = pulses[b] + 1;
                if (prev_en[b]) wide_err = wide_err + 1;
            end
        end
        prev_en = step_en;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        for (int b = 0; b < NB; b++) pulses[b] = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input int ph);
        do @(negedge clk); while ((cyc % PER) != ph);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(3);
        check("R6 during reset", int'(step_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 first cycle after reset", int'(step_en), 0);
        clr_counts();
    endtask

    // R3: exact strobe cycle, button high from reset release
    task automatic t_latency();
        @(negedge clk);
        rst = 1'b1;
        btn_raw = 4'b0001;
        wait_cyc(2);
        rst = 1'b0;
        clr_counts();
        do @(negedge clk); while (cyc != PER + 1);
        check("R3 low after E+1", int'(step_en[0]), 0);
        @(negedge clk);
        check("R3 high after E+2", int'(step_en[0]), 1);
        @(negedge clk);
        check("R3 low after E+3", int'(step_en[0]), 0);
        // R4: keep holding through several samples
        wait_cyc(5 * PER);
        check("R4 held gives one strobe", pulses[0], 1);
        btn_raw = '0;
        wait_cyc(3 * PER);
        // R8
        check("R8 release silent", pulses[0], 1);
        btn_raw = 4'b0001;
        wait_cyc(3 * PER);
        check("R4 re-press after low sample", pulses[0], 2);
        btn_raw = '0;
        wait_cyc(3 * PER);
    endtask

    // R2: pulse wholly between two samples
    task automatic t_glitch();
        do_reset();
        wait_phase(1);
        btn_raw[1] = 1'b1;
        wait_cyc(4);
        btn_raw[1] = 1'b0;
        wait_cyc(3 * PER);
        check("R2 between-sample pulse ignored", pulses[1], 0);
    endtask

    // R7 and R8: bounce on press and on release
    task automatic t_bounce();
        do_reset();
        wait_phase(2);
        for (int k = 0; k < 9; k++) begin
            btn_raw[2] = (k % 2 == 0);
            @(negedge clk);
        end
        btn_raw[2] = 1'b1;
        wait_cyc(4 * PER);
        check("R7 bouncy press one strobe", pulses[2], 1);
        wait_phase(3);
        for (int k = 0; k < 7; k++) begin
            btn_raw[2] = (k % 2 == 1);
            @(negedge clk);
        end
        btn_raw[2] = 1'b0;
        wait_cyc(4 * PER);
        check("R8 bouncy release silent", pulses[2], 1);
    endtask

    // R5: simultaneous and single-channel presses
    task automatic t_channels();
        do_reset();
        btn_raw = 4'b1111;
        wait_cyc(3 * PER);
        for (int b = 0; b < NB; b++)
            check("R5 all channels one strobe", pulses[b], 1);
        btn_raw = '0;
        wait_cyc(3 * PER);
        clr_counts();
        btn_raw = 4'b1000;
        wait_cyc(3 * PER);
        check("R5 pressed channel", pulses[3], 1);
        check("R5 other channels quiet", pulses[0] + pulses[1] + pulses[2], 0);
        btn_raw = '0;
        wait_cyc(3 * PER);
    endtask

    // R6: reset one cycle before a due strobe
    task automatic t_reset_mid();
        do_reset();
        btn_raw = 4'b0001;
        wait_phase(1);
        rst = 1'b1;
        @(negedge clk);
        check("R6 strobe cancelled by reset", int'(step_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 quiet after reset", int'(step_en), 0);
        btn_raw = '0;
        wait_cyc(3 * PER);
    endtask

    // R9: downstream 8-bit counter advances once per press
    task automatic t_counting();
        logic [7:0] step_cnt;
        do_reset();
        step_cnt = '0;
        for (int p = 0; p < 5; p++) begin
            btn_raw[0] = 1'b1;
            for (int k = 0; k < 3 * PER; k++) begin
                @(negedge clk);
                if (step_en[0]) step_cnt = step_cnt + 1'b1;
            end
            btn_raw[0] = 1'b0;
            for (int k = 0; k < 3 * PER; k++) begin
                @(negedge clk);
                if (step_en[0]) step_cnt = step_cnt + 1'b1;
            end
        end
        check("R9 counter steps per press", int'(step_cnt), 5);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clr_counts();
        wait_cyc(2);
        t_latency();
        t_glitch();
        t_bounce();
        t_channels();
        t_reset_mid();
        t_counting();
        // R1
        check("R1 strobe width one cycle", wide_err, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule